// File: doc/BRIEF.md
# Phase-Synchronizable PWM Time Base

This block is a PWM generator built around a time-base counter that can count up, count down, or count up and then down. A pulse on the sync input loads a programmable phase value into the running counter, and counting carries on from that value toward the period. Several instances can be chained into a group. One instance has zero phase and raises its sync output on counter zero. That output drives the sync input of the others, so each of them runs at a fixed offset from the first.

The sync output is a one-clock pulse. It is raised by a software force input or by any internal event enabled in a six-bit source mask. The sources are counter zero, three compare matches and two external digital-compare event inputs. The period, the four compare values and the phase are written through a simple write port into shadow copies. The whole set moves to the active copies on a clock edge where the counter is zero, so the duty cycle and the phase can change while the generator runs. Output A goes high after counter zero and low after a compare-A match.

Top module: `pwm_sync_timebase`

## Requirements
- R1: In count mode 2'b00 (up), the counter steps by one each clock and goes to zero on the clock after any cycle in which it is at or above the active period. A phase value equal to the period therefore wraps to zero on the next tick.
- R2: In count mode 2'b01 (down), the counter steps down by one each clock and reloads the active period on the clock after a cycle in which it is zero.
- R3: In count mode 2'b10 (up-down), the counter rises to the active period, turns and falls to zero, then turns up again. `count_up` shows the current direction.
- R4: When `sync_in` is high and phase loading is enabled, the counter holds the active phase value after the next edge. In up-down mode the direction after that load is taken from control bit 3 (1 = up). Up mode sets the direction to up and down mode sets it to down.
- R5: When control bit 2 (phase loading enable) is 0, `sync_in` has no effect and the counter keeps its normal sequence.
- R6: `sync_out` is high in the cycle after `sw_force` is high or after an enabled source fires. The sources are enabled by mask bits 9:4 of the control word: bit 4 counter zero, bit 5 compare-B match, bit 6 compare-C match, bit 7 compare-D match, bit 8 `dc_evt_a`, bit 9 `dc_evt_b`. A force and a hardware event in the same cycle give a single one-cycle pulse.
- R7: Writes to addresses 1 to 6 (period, compare A, compare B, compare C, compare D, phase) change only the shadow copies. All active copies take the shadow values on the clock edge of a cycle in which the counter is zero. The counter is not stopped by the write.
- R8: `out_a` goes high the cycle after counter zero and low the cycle after a compare-A match. An active compare-A of 0 keeps it low, and compare-A above the active period keeps it high.
- R9: After reset the counter is 0, `count_up` is 1, `out_a` and `sync_out` are 0, and every register holds 0.
- R10: Address 0 writes the control word directly, with no shadow. Bits 1:0 select the count mode (2'b00 up, 2'b01 down, 2'b10 up-down; 2'b11 behaves as up).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 to 6 shadowed values) |
| wr_data | input | CNT_W | Write data |
| sync_in | input | 1 | Phase-load request pulse |
| sw_force | input | 1 | Software force of a sync-out pulse |
| dc_evt_a | input | 1 | Digital-compare event A |
| dc_evt_b | input | 1 | Digital-compare event B |
| tb_count | output | CNT_W | Time-base counter value |
| count_up | output | 1 | Counting direction, 1 = up |
| out_a | output | 1 | PWM output A |
| sync_out | output | 1 | Sync pulse for downstream generators |

## Verification
A software force and a counter-zero event with the zero source enabled can land in the same cycle. The bench provokes this by raising `sw_force` in exactly the cycle where the sampled counter reads zero. It then checks that `sync_out` is high for that one following cycle and low on the cycle after, with no stretched or doubled pulse. A cycle-level model in the bench is advanced alongside six configurations that mix modes, masks and periodic sync pulses. That model covers other overlaps as well, such as a sync load in the same cycle as a shadow transfer.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  typedef enum logic [1:0] {
    CM_UP   = 2'b00,
    CM_DOWN = 2'b01,
    CM_UPDN = 2'b10,
    CM_RSVD = 2'b11
  } cnt_mode_e;

  typedef struct packed {
    logic [5:0] mask;
    logic       sync_up;
    logic       ph_en;
    cnt_mode_e  mode;
  } ctrl_t;

  localparam int NUM_SHADOW   = 6;
  localparam int NUM_SYNC_SRC = 6;
  localparam int NUM_CMP_SYNC = 3;

  // shadow slot index = write address - 1
  localparam int IDX_PRD   = 0;
  localparam int IDX_CMPA  = 1;
  localparam int IDX_CMPB  = 2;
  localparam int IDX_CMPC  = 3;
  localparam int IDX_CMPD  = 4;
  localparam int IDX_PHASE = 5;

  localparam logic [2:0] ADDR_CTRL = 3'd0;

  // control word bit positions
  localparam int CF_MODE = 0;
  localparam int CF_PHEN = 2;
  localparam int CF_SDIR = 3;
  localparam int CF_MASK = 4;
  localparam int CTRL_W  = CF_MASK + NUM_SYNC_SRC;

endpackage

// File: rtl/pwm_tb_regs.sv
module pwm_tb_regs
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [2:0]                            wr_addr,
  input  logic [CNT_W-1:0]                      wr_data,
  input  logic                                  load_now,
  output ctrl_t                                 ctrl,
  output logic [NUM_SHADOW-1:0][CNT_W-1:0]      act_val,
  output logic [CNT_W-1:0]                      prd_shd
);

  logic [NUM_SHADOW-1:0][CNT_W-1:0] shd_val;

  function automatic ctrl_t decode_ctrl(logic [CNT_W-1:0] d);
    ctrl_t c;
    c.mode    = cnt_mode_e'(d[CF_MODE +: 2]);
    c.ph_en   = d[CF_PHEN];
    c.sync_up = d[CF_SDIR];
    c.mask    = d[CF_MASK +: NUM_SYNC_SRC];
    return c;
  endfunction

  function automatic logic slot_hit(logic en, logic [2:0] a, int idx);
    return en && (a == 3'(idx + 1));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_en && wr_addr == ADDR_CTRL) begin
      ctrl <= decode_ctrl(wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_val <= '0;
      act_val <= '0;
    end else begin
      for (int i = 0; i < NUM_SHADOW; i++) begin
        if (slot_hit(wr_en, wr_addr, i)) shd_val[i] <= wr_data;
        if (load_now) act_val[i] <= shd_val[i];
      end
    end
  end

  assign prd_shd = shd_val[IDX_PRD];

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_mode_e        mode,
  input  logic             ph_en,
  input  logic             sync_up,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] phase,
  output logic [CNT_W-1:0] count,
  output logic             count_up
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // returns {next direction, next count}
  function automatic logic [CNT_W:0] step_fn(cnt_mode_e m, logic up,
                                             logic [CNT_W-1:0] c,
                                             logic [CNT_W-1:0] p);
    logic             n_up;
    logic [CNT_W-1:0] n_c;
    n_up = up;
    n_c  = c;
    case (m)
      CM_DOWN: begin
        n_up = 1'b0;
        n_c  = (c == '0) ? p : c - ONE;
      end
      CM_UPDN: begin
        if (up) begin
          if (c >= p) begin
            n_up = 1'b0;
            n_c  = (c == '0) ? '0 : c - ONE;
          end else begin
            n_c = c + ONE;
          end
        end else begin
          if (c == '0) begin
            n_up = 1'b1;
            n_c  = (p == '0) ? '0 : ONE;
          end else begin
            n_c = c - ONE;
          end
        end
      end
      default: begin
        n_up = 1'b1;
        n_c  = (c >= p) ? '0 : c + ONE;
      end
    endcase
    return {n_up, n_c};
  endfunction

  function automatic logic dir_after_load(cnt_mode_e m, logic s_up);
    return (m == CM_UPDN) ? s_up : (m != CM_DOWN);
  endfunction

  logic sync_take;
  assign sync_take = sync_in & ph_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      count_up <= 1'b1;
    end else if (sync_take) begin
      count    <= phase;
      count_up <= dir_after_load(mode, sync_up);
    end else begin
      {count_up, count} <= step_fn(mode, count_up, count, prd);
    end
  end

endmodule

// File: rtl/pwm_tb_events.sv
module pwm_tb_events
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [CNT_W-1:0]                      count,
  input  logic [CNT_W-1:0]                      prd,
  input  logic [CNT_W-1:0]                      cmpa,
  input  logic [NUM_CMP_SYNC-1:0][CNT_W-1:0]    cmp_sync,
  input  logic [NUM_SYNC_SRC-1:0]               mask,
  input  logic                                  sw_force,
  input  logic                                  dc_a,
  input  logic                                  dc_b,
  output logic                                  evt_zero,
  output logic [NUM_SYNC_SRC-1:0]               src_hit,
  output logic                                  sync_out,
  output logic                                  out_a
);

  logic [NUM_CMP_SYNC-1:0] cmp_hit;
  logic                    evt_cmpa;

  generate
    for (genvar gi = 0; gi < NUM_CMP_SYNC; gi++) begin : g_cmp
      assign cmp_hit[gi] = (count == cmp_sync[gi]);
    end
  endgenerate

  assign evt_zero = (count == '0);
  assign evt_cmpa = (count == cmpa);
  assign src_hit  = mask & {dc_b, dc_a, cmp_hit, evt_zero};

  function automatic logic out_next(logic cur, logic zero, logic match,
                                    logic [CNT_W-1:0] ca,
                                    logic [CNT_W-1:0] p);
    if (ca == '0)      return 1'b0;
    else if (ca > p)   return 1'b1;
    else if (zero)     return 1'b1;
    else if (match)    return 1'b0;
    else               return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_out <= 1'b0;
      out_a    <= 1'b0;
    end else begin
      sync_out <= sw_force | (|src_hit);
      out_a    <= out_next(out_a, evt_zero, evt_cmpa, cmpa, prd);
    end
  end

endmodule

// File: rtl/pwm_sync_timebase.sv
module pwm_sync_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             sync_in,
  input  logic             sw_force,
  input  logic             dc_evt_a,
  input  logic             dc_evt_b,
  output logic [CNT_W-1:0] tb_count,
  output logic             count_up,
  output logic             out_a,
  output logic             sync_out
);

  ctrl_t                                 ctrl;
  logic [NUM_SHADOW-1:0][CNT_W-1:0]      act_val;
  logic [CNT_W-1:0]                      prd_shd;
  logic [CNT_W-1:0]                      prd_act;
  logic [CNT_W-1:0]                      phase_act;
  logic [CNT_W-1:0]                      cmpa_act;
  logic [NUM_CMP_SYNC-1:0][CNT_W-1:0]    cmp_sync;
  logic                                  evt_zero;
  logic [NUM_SYNC_SRC-1:0]               src_hit;
  cnt_mode_e                             mode;
  logic                                  ph_en;

  assign prd_act   = act_val[IDX_PRD];
  assign phase_act = act_val[IDX_PHASE];
  assign cmpa_act  = act_val[IDX_CMPA];
  assign cmp_sync  = {act_val[IDX_CMPD], act_val[IDX_CMPC], act_val[IDX_CMPB]};
  assign mode      = ctrl.mode;
  assign ph_en     = ctrl.ph_en;

  pwm_tb_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .load_now (evt_zero),
    .ctrl     (ctrl),
    .act_val  (act_val),
    .prd_shd  (prd_shd)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .ph_en    (ph_en),
    .sync_up  (ctrl.sync_up),
    .sync_in  (sync_in),
    .prd      (prd_act),
    .phase    (phase_act),
    .count    (tb_count),
    .count_up (count_up)
  );

  pwm_tb_events #(.CNT_W(CNT_W)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (tb_count),
    .prd      (prd_act),
    .cmpa     (cmpa_act),
    .cmp_sync (cmp_sync),
    .mask     (ctrl.mask),
    .sw_force (sw_force),
    .dc_a     (dc_evt_a),
    .dc_b     (dc_evt_b),
    .evt_zero (evt_zero),
    .src_hit  (src_hit),
    .sync_out (sync_out),
    .out_a    (out_a)
  );

endmodule

// File: rtl/pwm_tb_checker.sv
module pwm_tb_checker
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input cnt_mode_e               mode,
  input logic                    ph_en,
  input logic                    sync_in,
  input logic                    sw_force,
  input logic [CNT_W-1:0]        count,
  input logic                    count_up,
  input logic                    out_a,
  input logic                    sync_out,
  input logic [CNT_W-1:0]        prd_act,
  input logic [CNT_W-1:0]        prd_shd,
  input logic [CNT_W-1:0]        phase_act,
  input logic [CNT_W-1:0]        cmpa_act,
  input logic                    evt_zero,
  input logic [NUM_SYNC_SRC-1:0] src_hit
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic loading;
  assign loading = sync_in && ph_en;

  p_up_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_UP && !loading && count >= prd_act) |=> (count == '0));

  p_down_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_DOWN && !loading && count == '0) |=> (count == $past(prd_act)));

  p_updn_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_UPDN && !loading && count_up && count >= prd_act && count != '0)
    |=> !count_up);

  p_phase_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loading |=> (count == $past(phase_act)));

  p_sync_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_UP && sync_in && !ph_en && count < prd_act)
    |=> (count == $past(count) + ONE));

  p_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_force |=> sync_out);

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_force && src_hit == '0) |=> !sync_out);

  p_shadow_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_zero |=> (prd_act == $past(prd_shd)));

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_zero |=> $stable(prd_act));

  p_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpa_act == '0) |=> !out_a);

  p_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpa_act > prd_act) |=> out_a);

endmodule

bind pwm_sync_timebase pwm_tb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .ph_en     (ph_en),
  .sync_in   (sync_in),
  .sw_force  (sw_force),
  .count     (tb_count),
  .count_up  (count_up),
  .out_a     (out_a),
  .sync_out  (sync_out),
  .prd_act   (prd_act),
  .prd_shd   (prd_shd),
  .phase_act (phase_act),
  .cmpa_act  (cmpa_act),
  .evt_zero  (evt_zero),
  .src_hit   (src_hit)
);

// File: tb/pwm_sync_timebase_tb.sv
`timescale 1ns/1ps
module pwm_sync_timebase_tb;

  localparam int W = 16;
  localparam int NV = 6;

  // stimulus table: mode, period, compare A, phase, sync mask, phase enable,
  // direction after sync, sync_in spacing, requirement tag
  localparam int    V_MODE [NV] = '{0, 1, 2, 0, 2, 0};
  localparam int    V_PRD  [NV] = '{9, 12, 8, 6, 10, 15};
  localparam int    V_CMPA [NV] = '{4, 5, 3, 0, 15, 7};
  localparam int    V_PH   [NV] = '{3, 7, 5, 6, 2, 0};
  localparam int    V_MASK [NV] = '{1, 2, 5, 8, 1, 48};
  localparam int    V_PHEN [NV] = '{1, 1, 1, 1, 0, 1};
  localparam int    V_SDIR [NV] = '{0, 0, 0, 0, 1, 1};
  localparam int    V_SPER [NV] = '{23, 31, 17, 11, 13, 29};
  localparam string V_REQ  [NV] = '{"R1", "R2", "R4", "R8", "R3", "R6"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic sync_in = 1'b0, sw_force = 1'b0, dc_evt_a = 1'b0, dc_evt_b = 1'b0;
  logic [W-1:0] tb_count;
  logic count_up, out_a, sync_out;

  always #2.5 clk = ~clk;

  pwm_sync_timebase #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .sw_force(sw_force), .dc_evt_a(dc_evt_a), .dc_evt_b(dc_evt_b),
    .tb_count(tb_count), .count_up(count_up), .out_a(out_a), .sync_out(sync_out)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model state (built from the requirements)
  int m_cnt, m_mode;
  bit m_up, m_out, m_sync, m_phen, m_sdir;
  bit [5:0] m_mask;
  int sh [7];
  int ac [7];

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_up = 1; m_out = 0; m_sync = 0;
    m_mode = 0; m_phen = 0; m_sdir = 0; m_mask = '0;
    for (int i = 0; i < 7; i++) begin sh[i] = 0; ac[i] = 0; end
  endtask

  task automatic model_step(bit w, int a, int d, bit si, bit sf, bit da, bit db);
    bit z, n_up, n_out, n_sync;
    int n_cnt, p;
    z = (m_cnt == 0);
    p = ac[1];
    n_sync = sf | (m_mask[0] & z) | (m_mask[1] & (m_cnt == ac[3])) |
             (m_mask[2] & (m_cnt == ac[4])) | (m_mask[3] & (m_cnt == ac[5])) |
             (m_mask[4] & da) | (m_mask[5] & db);
    if (ac[2] == 0) n_out = 0;
    else if (ac[2] > p) n_out = 1;
    else if (z) n_out = 1;
    else if (m_cnt == ac[2]) n_out = 0;
    else n_out = m_out;
    if (si && m_phen) begin
      n_cnt = ac[6];
      n_up = (m_mode == 2) ? m_sdir : (m_mode != 1);
    end else if (m_mode == 1) begin
      n_up = 0;
      n_cnt = z ? p : m_cnt - 1;
    end else if (m_mode == 2) begin
      if (m_up) begin
        if (m_cnt >= p) begin n_up = 0; n_cnt = z ? 0 : m_cnt - 1; end
        else begin n_up = 1; n_cnt = m_cnt + 1; end
      end else begin
        if (z) begin n_up = 1; n_cnt = (p == 0) ? 0 : 1; end
        else begin n_up = 0; n_cnt = m_cnt - 1; end
      end
    end else begin
      n_up = 1;
      n_cnt = (m_cnt >= p) ? 0 : m_cnt + 1;
    end
    if (z) for (int i = 1; i < 7; i++) ac[i] = sh[i];
    if (w) begin
      if (a == 0) begin
        m_mode = d & 3; m_phen = d[2]; m_sdir = d[3]; m_mask = d[9:4];
      end else if (a < 7) sh[a] = d;
    end
    m_cnt = n_cnt; m_up = n_up; m_out = n_out; m_sync = n_sync;
  endtask

  task automatic cyc(bit w = 0, int a = 0, int d = 0, bit si = 0, bit sf = 0,
                     bit da = 0, bit db = 0);
    wr_en = w; wr_addr = 3'(a); wr_data = W'(d);
    sync_in = si; sw_force = sf; dc_evt_a = da; dc_evt_b = db;
    model_step(w, a, d, si, sf, da, db);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 0; sync_in = 0; sw_force = 0; dc_evt_a = 0; dc_evt_b = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic setup(int mode, int phen, int sdir, int mask, int prd, int ca,
                       int cb, int cc, int cd, int ph);
    do_reset();
    cyc(1, 0, mode | (phen << 2) | (sdir << 3) | (mask << 4));
    cyc(1, 2, ca); cyc(1, 3, cb); cyc(1, 4, cc); cyc(1, 5, cd); cyc(1, 6, ph);
    cyc(1, 1, prd);
    cyc();
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int mism, mx;
    @(negedge clk);

    // R9: reset state
    do_reset();
    check("R9", int'(tb_count), 0, "count after reset");
    check("R9", int'(count_up), 1, "direction after reset");
    check("R9", int'(out_a), 0, "out_a after reset");
    check("R9", int'(sync_out), 0, "sync_out after reset");

    // table walk against the model
    for (int v = 0; v < NV; v++) begin
      setup(V_MODE[v], V_PHEN[v], V_SDIR[v], V_MASK[v], V_PRD[v], V_CMPA[v],
            V_PRD[v] / 2, V_PRD[v] - 1, 1, V_PH[v]);
      mism = 0;
      for (int c = 0; c < 120; c++) begin
        cyc(0, 0, 0, (c % V_SPER[v]) == V_SPER[v] - 1, (v == 5) && (c % 17 == 5),
            (c % 13) == 0, (c % 19) == 4);
        if (int'(tb_count) != m_cnt || out_a != m_out || sync_out != m_sync ||
            count_up != m_up) mism++;
      end
      check(V_REQ[v], mism, 0, $sformatf("vector %0d mismatching cycles", v));
    end

    // R7: period change while running waits for counter zero
    setup(0, 0, 0, 0, 9, 4, 0, 0, 0, 0);
    while (tb_count != 5) cyc();
    cyc(1, 1, 4);
    mx = int'(tb_count);
    while (tb_count != 0) begin
      cyc();
      if (int'(tb_count) > mx) mx = int'(tb_count);
    end
    check("R7", mx, 9, "old period still in force");
    for (int k = 1; k <= 4; k++) begin
      cyc();
      check("R7", int'(tb_count), k, "count under new period");
    end
    cyc();
    check("R7", int'(tb_count), 0, "wrap at new period");

    // R6: force and zero event in the same cycle give one pulse
    setup(0, 0, 0, 1, 5, 2, 0, 0, 0, 0);
    check("R6", int'(tb_count), 0, "count is zero before force");
    cyc(0, 0, 0, 0, 1);
    check("R6", int'(sync_out), 1, "pulse after force on zero");
    cyc();
    check("R6", int'(sync_out), 0, "pulse ends after one cycle");

    // R5: sync ignored while phase loading is disabled
    setup(0, 0, 0, 0, 9, 4, 0, 0, 0, 6);
    while (tb_count != 3) cyc();
    cyc(0, 0, 0, 1);
    check("R5", int'(tb_count), 4, "count after ignored sync");

    // R4 / R10: up-down load with programmed direction
    setup(2, 1, 0, 0, 8, 3, 0, 0, 0, 5);
    while (tb_count != 2) cyc();
    cyc(0, 0, 0, 1);
    check("R4", int'(tb_count), 5, "phase loaded in up-down");
    cyc();
    check("R4", int'(tb_count), 4, "counts down after load with dir 0");
    check("R10", int'(count_up), 0, "mode 2'b10 direction after load");
    cyc(1, 0, 2 | (1 << 2) | (1 << 3));
    cyc(0, 0, 0, 1);
    cyc();
    check("R4", int'(tb_count), 6, "counts up after load with dir 1");

    // R1: phase equal to period wraps to zero on the next tick
    setup(0, 1, 0, 0, 9, 4, 0, 0, 0, 9);
    while (tb_count != 2) cyc();
    cyc(0, 0, 0, 1);
    check("R1", int'(tb_count), 9, "phase equal to period loaded");
    cyc();
    check("R1", int'(tb_count), 0, "wrap after phase equals period");

    // R2: down mode reload
    setup(1, 0, 0, 0, 3, 1, 0, 0, 0, 0);
    cyc();
    check("R2", int'(tb_count), 3, "reload of period from zero");
    cyc(); cyc(); cyc(); cyc();
    check("R2", int'(tb_count), 3, "second reload");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule